// File: doc/BRIEF.md
# Display Controller Power-Mode Sequencer

This block decides which operating mode a low-power display controller is in and when it may leave its reset process. A reset has three possible causes: the power-on event, an active-low reset pin, and a software reset command from the host. Each cause opens a busy window of fixed length. While the window is open, the block reports itself as resetting and as busy, and it discards every host command except a status read. When the window closes, the block holds its control registers at their reset values. The display-enable bit clears to zero, and the configuration register loads from the configuration pins.

After reset, the display-enable bit alone selects the mode: Sleep when it is clear, Normal when it is set. The block drives the charge-pump enable, the display-driver enable and the capacitor-drain enable from the mode. The driver enable also waits for a power-ready input, which shows that the internal supply voltages have come back. Every mode change is taken from registers that update on the clock.

Top module: `lcd_pwr_sequencer`

## Requirements
- R1: `op_mode` is 2'b00 in Reset, 2'b10 in Sleep and 2'b11 in Normal. `drain_en` is 1 only in Reset. `pump_en` is 1 only in Normal. In Sleep, `drain_en`, `pump_en` and `drv_en` are all 0.
- R2: After `rst` falls, the block stays in Reset with `stat_rs` = 1 for exactly POR_CYC + BUSY_CYC rising edges. After that many edges, `stat_rs` reads 0.
- R3: A software reset command (`cmd_op` = 2'd2) accepted outside reset sets `stat_rs` at the next edge. `stat_rs` clears BUSY_CYC + 1 edges after the edge that takes the command.
- R4: The reset pin `rst_pin_n` passes through two flops, so a low level shows on `stat_rs` at the third edge. The block stays in Reset for as long as the pin is low. `stat_rs` clears BUSY_CYC + 2 edges after the pin returns high.
- R5: `stat_bz` always equals `stat_rs`. Both are 1 throughout any reset process and 0 otherwise.
- R6: While `stat_rs` is 1, a display-enable command (`cmd_op` = 2'd1) and a configuration write (`cmd_op` = 2'd3) have no effect. Only a status read (`cmd_op` = 2'd0) is processed.
- R7: A status read makes `stat_vld` pulse high for one cycle after the edge that takes it. `stat_word` then holds the reset flag in bit 7, the busy flag in bit 6, the mode in bits 1:0 and zeros elsewhere.
- R8: When reset ends, the display-enable bit is 0, so the mode is Sleep. `cfg_out` equals `cfg_pins`.
- R9: A display-enable command outside reset takes bit 0 of `cmd_data` as the enable. The mode changes to Normal (1) or Sleep (0) at the next edge.
- R10: `drv_en` is 1 only in Normal and only when `pwr_ready` was high at the previous edge. It drops one edge after `pwr_ready` falls.
- R11: A configuration write outside reset loads `cmd_data` into `cfg_out` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Power-on event, synchronous, active high |
| rst_pin_n | input | 1 | Asynchronous reset pin, active low |
| cmd_valid | input | 1 | Host command strobe |
| cmd_op | input | 2 | Command: 0 status read, 1 display enable, 2 software reset, 3 config write |
| cmd_data | input | CFG_W | Command operand |
| cfg_pins | input | CFG_W | Configuration pin values |
| pwr_ready | input | 1 | Internal voltages restored |
| op_mode | output | 2 | Operating mode |
| stat_rs | output | 1 | Reset in progress |
| stat_bz | output | 1 | Busy |
| stat_vld | output | 1 | Status word valid |
| stat_word | output | 8 | Status word |
| cfg_out | output | CFG_W | Pin-configurable control register |
| pump_en | output | 1 | Charge-pump enable |
| drv_en | output | 1 | Row/column driver enable |
| drain_en | output | 1 | Capacitor-drain enable |

## Verification
Each result has its own latency after a stimulus. Command effects, status responses and driver-enable changes appear one edge after the input. The pin-reset flag appears at the third edge because of the two synchronizer flops. The reset windows last POR_CYC + BUSY_CYC, BUSY_CYC + 1 or BUSY_CYC + 2 edges. The bench drives inputs on the falling edge and samples outputs on the next falling edge. It measures each reset window by counting rising edges until the reset flag clears, and it compares that count with the expected total.

// File: rtl/lcd_pwr_pkg.sv
package lcd_pwr_pkg;

    typedef enum logic [1:0] {
        MODE_RESET  = 2'b00,
        MODE_SLEEP  = 2'b10,
        MODE_NORMAL = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        CMD_STATUS = 2'd0,
        CMD_DISP   = 2'd1,
        CMD_SYSRST = 2'd2,
        CMD_CFG    = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        SQ_POR  = 2'd0,
        SQ_BUSY = 2'd1,
        SQ_RUN  = 2'd2
    } seq_e;

    typedef struct packed {
        logic pump;
        logic drv;
        logic drain;
    } pwr_en_t;

    localparam int STAT_W = 8;

    function automatic mode_e mode_of(input logic in_reset, input logic disp_en);
        if (in_reset)     return MODE_RESET;
        else if (disp_en) return MODE_NORMAL;
        else              return MODE_SLEEP;
    endfunction

    function automatic logic [STAT_W-1:0] stat_pack(input logic rs, input logic bz,
                                                    input mode_e m);
        return {rs, bz, 4'b0000, m};
    endfunction

endpackage

// File: rtl/lcd_pwr_pin_sync.sv
module lcd_pwr_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic pin_low
);
    logic [STAGES-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[STAGES-2:0], pin_n};
    end

    assign pin_low = ~sync_q[STAGES-1];
endmodule

// File: rtl/lcd_pwr_reset_seq.sv
module lcd_pwr_reset_seq
    import lcd_pwr_pkg::*;
#(
    parameter int POR_CYC  = 2400000,
    parameter int BUSY_CYC = 800
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_low,
    input  logic sw_reset,
    output logic in_reset
);
    localparam int MAXC  = (POR_CYC > BUSY_CYC) ? POR_CYC : BUSY_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] POR_LAST  = CNT_W'(POR_CYC - 1);
    localparam logic [CNT_W-1:0] BUSY_LAST = CNT_W'(BUSY_CYC - 1);

    seq_e             state_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_POR;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                SQ_POR: begin
                    if (cnt_q == POR_LAST) begin
                        state_q <= SQ_BUSY;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SQ_BUSY: begin
                    if (pin_low) begin
                        cnt_q <= '0;
                    end else if (cnt_q == BUSY_LAST) begin
                        state_q <= SQ_RUN;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    if (pin_low || sw_reset) begin
                        state_q <= SQ_BUSY;
                        cnt_q   <= '0;
                    end
                end
            endcase
        end
    end

    assign in_reset = (state_q != SQ_RUN);

    // R4: a pin held low keeps the busy window open
    p_pin_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_BUSY && pin_low) |=> (state_q == SQ_BUSY));

    // R3: a software reset from run state opens the busy window
    p_sw_enter_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_RUN && sw_reset) |=> (state_q == SQ_BUSY && cnt_q == '0));

    // R2: leaving power-on wait always lands in busy
    p_por_next_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_POR && cnt_q == POR_LAST) |=> (state_q == SQ_BUSY));
endmodule

// File: rtl/lcd_pwr_ctrl_regs.sv
module lcd_pwr_ctrl_regs
    import lcd_pwr_pkg::*;
#(
    parameter int CFG_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_reset,
    input  logic             cmd_valid,
    input  cmd_e             cmd_op,
    input  logic [CFG_W-1:0] cmd_data,
    input  logic [CFG_W-1:0] cfg_pins,
    output logic             disp_en,
    output logic [CFG_W-1:0] cfg_q,
    output logic             sw_reset
);
    logic take;

    assign take     = cmd_valid && !in_reset;
    assign sw_reset = take && (cmd_op == CMD_SYSRST);

    always_ff @(posedge clk) begin
        if (rst || in_reset) begin
            disp_en <= 1'b0;
            cfg_q   <= cfg_pins;
        end else if (take) begin
            if (cmd_op == CMD_DISP) disp_en <= cmd_data[0];
            if (cmd_op == CMD_CFG)  cfg_q   <= cmd_data;
        end
    end

    // R8: registers sit at defaults while resetting
    p_disp_dflt_r8: assert property (@(posedge clk) disable iff (rst)
        in_reset |=> !disp_en);
    p_cfg_dflt_r8: assert property (@(posedge clk) disable iff (rst)
        in_reset |=> (cfg_q == $past(cfg_pins)));

    // R11: configuration write lands next edge
    p_cfg_write_r11: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !in_reset && cmd_op == CMD_CFG) |=> (cfg_q == $past(cmd_data)));
endmodule

// File: rtl/lcd_pwr_out_stage.sv
module lcd_pwr_out_stage
    import lcd_pwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_reset,
    input  logic              disp_en,
    input  logic              pwr_ready,
    input  logic              stat_req,
    output mode_e             mode,
    output pwr_en_t           en,
    output logic              stat_vld,
    output logic [STAT_W-1:0] stat_word
);
    logic ready_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_q   <= 1'b0;
            stat_vld  <= 1'b0;
            stat_word <= '0;
        end else begin
            ready_q  <= pwr_ready;
            stat_vld <= stat_req;
            if (stat_req) stat_word <= stat_pack(in_reset, in_reset, mode);
        end
    end

    always_comb begin
        mode     = mode_of(in_reset, disp_en);
        en.drain = (mode == MODE_RESET);
        en.pump  = (mode == MODE_NORMAL);
        en.drv   = (mode == MODE_NORMAL) && ready_q;
    end

    // R1: drain never overlaps pump or drivers
    p_drain_excl_r1: assert property (@(posedge clk) disable iff (rst)
        en.drain |-> (!en.pump && !en.drv));

    // R10: drivers need ready seen at the previous edge
    p_drv_ready_r10: assert property (@(posedge clk) disable iff (rst)
        en.drv |-> $past(pwr_ready));

    // R7: a status request yields one valid pulse
    p_stat_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        stat_req |=> stat_vld);
    p_stat_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !stat_req |=> !stat_vld);
endmodule

// File: rtl/lcd_pwr_sequencer.sv
module lcd_pwr_sequencer
    import lcd_pwr_pkg::*;
#(
    parameter int POR_CYC  = 2400000,
    parameter int BUSY_CYC = 800,
    parameter int CFG_W    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rst_pin_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [CFG_W-1:0] cmd_data,
    input  logic [CFG_W-1:0] cfg_pins,
    input  logic             pwr_ready,
    output logic [1:0]       op_mode,
    output logic             stat_rs,
    output logic             stat_bz,
    output logic             stat_vld,
    output logic [7:0]       stat_word,
    output logic [CFG_W-1:0] cfg_out,
    output logic             pump_en,
    output logic             drv_en,
    output logic             drain_en
);
    logic    pin_low;
    logic    sw_reset;
    logic    in_reset;
    logic    disp_en;
    logic    stat_req;
    cmd_e    op;
    mode_e   mode;
    pwr_en_t en;

    assign op       = cmd_e'(cmd_op);
    assign stat_req = cmd_valid && (op == CMD_STATUS);

    lcd_pwr_pin_sync #(.STAGES(2)) i_sync (
        .clk(clk), .rst(rst), .pin_n(rst_pin_n), .pin_low(pin_low)
    );

    lcd_pwr_reset_seq #(.POR_CYC(POR_CYC), .BUSY_CYC(BUSY_CYC)) i_seq (
        .clk(clk), .rst(rst), .pin_low(pin_low), .sw_reset(sw_reset),
        .in_reset(in_reset)
    );

    lcd_pwr_ctrl_regs #(.CFG_W(CFG_W)) i_regs (
        .clk(clk), .rst(rst), .in_reset(in_reset), .cmd_valid(cmd_valid),
        .cmd_op(op), .cmd_data(cmd_data), .cfg_pins(cfg_pins),
        .disp_en(disp_en), .cfg_q(cfg_out), .sw_reset(sw_reset)
    );

    lcd_pwr_out_stage i_out (
        .clk(clk), .rst(rst), .in_reset(in_reset), .disp_en(disp_en),
        .pwr_ready(pwr_ready), .stat_req(stat_req), .mode(mode), .en(en),
        .stat_vld(stat_vld), .stat_word(stat_word)
    );

    assign op_mode  = mode;
    assign stat_rs  = in_reset;
    assign stat_bz  = in_reset;
    assign pump_en  = en.pump;
    assign drv_en   = en.drv;
    assign drain_en = en.drain;

    // R9: display enable command sets the mode next edge
    p_disp_mode_r9: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !stat_rs && op == CMD_DISP) |=>
        (op_mode == ($past(cmd_data[0]) ? 2'b11 : 2'b10)));

    // R6: commands other than status read are dropped while resetting
    p_discard_r6: assert property (@(posedge clk) disable iff (rst)
        (stat_rs && cmd_valid && op == CMD_DISP) |=> (op_mode != 2'b11));
endmodule

// File: tb/test_lcd_pwr_sequencer.sv
module test_lcd_pwr_sequencer;
    localparam int POR  = 20;
    localparam int BUSY = 6;
    localparam logic [3:0] PINS = 4'hA;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rst_pin_n = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic [3:0] cmd_data = 4'h0;
    logic       pwr_ready = 1'b0;
    logic [1:0] op_mode;
    logic       stat_rs, stat_bz, stat_vld, pump_en, drv_en, drain_en;
    logic [7:0] stat_word;
    logic [3:0] cfg_out;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    lcd_pwr_sequencer #(.POR_CYC(POR), .BUSY_CYC(BUSY), .CFG_W(4)) i_lcd_pwr_sequencer (
        .clk(clk), .rst(rst), .rst_pin_n(rst_pin_n), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_data(cmd_data), .cfg_pins(PINS),
        .pwr_ready(pwr_ready), .op_mode(op_mode), .stat_rs(stat_rs),
        .stat_bz(stat_bz), .stat_vld(stat_vld), .stat_word(stat_word),
        .cfg_out(cfg_out), .pump_en(pump_en), .drv_en(drv_en), .drain_en(drain_en)
    );

    typedef struct packed {
        logic       v;
        logic [1:0] op;
        logic [3:0] d;
        logic       pr;
        logic [1:0] mode;
        logic       drv;
        logic [3:0] cfg;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{1'b1, 2'd1, 4'h1, 1'b0, 2'b11, 1'b0, 4'hA},
        '{1'b0, 2'd0, 4'h0, 1'b1, 2'b11, 1'b1, 4'hA},
        '{1'b1, 2'd1, 4'h0, 1'b1, 2'b10, 1'b0, 4'hA},
        '{1'b1, 2'd1, 4'h0, 1'b1, 2'b10, 1'b0, 4'hA},
        '{1'b1, 2'd1, 4'h1, 1'b1, 2'b11, 1'b1, 4'hA},
        '{1'b1, 2'd3, 4'h5, 1'b1, 2'b11, 1'b1, 4'h5},
        '{1'b0, 2'd0, 4'h0, 1'b0, 2'b11, 1'b0, 4'h5}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] op, input logic [3:0] d);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
        @(posedge clk); @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic count_to_run(input int already, output int n);
        n = already;
        while (stat_rs && n < 1000) begin
            check(stat_bz == stat_rs, "R5", stat_bz, stat_rs);
            check(op_mode == 2'b00, "R1", op_mode, 0);
            @(posedge clk); @(negedge clk);
            n++;
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check(op_mode == 2'b00 && drain_en && !pump_en && !drv_en, "R1", op_mode, 0);
        check(stat_rs && stat_bz, "R5", {stat_rs, stat_bz}, 3);
        rst = 1'b0;
        n = 0;
        while (n < 1000) begin
            @(posedge clk); @(negedge clk); n++;
            if (!stat_rs) break;
            if (stat_bz != stat_rs || op_mode != 2'b00) check(0, "R2", op_mode, 0);
        end
        check(n == POR + BUSY, "R2", n, POR + BUSY);
        check(op_mode == 2'b10 && !pump_en && !drain_en && !drv_en, "R8", op_mode, 2);
        check(cfg_out == PINS, "R8", cfg_out, PINS);

        foreach (VECS[i]) begin
            pwr_ready = VECS[i].pr;
            if (VECS[i].v) begin
                cmd_valid = 1'b1; cmd_op = VECS[i].op; cmd_data = VECS[i].d;
            end
            @(posedge clk); @(negedge clk);
            cmd_valid = 1'b0;
            check(op_mode == VECS[i].mode, "R9", op_mode, VECS[i].mode);
            check(pump_en == (VECS[i].mode == 2'b11), "R1", pump_en, VECS[i].mode == 2'b11);
            check(drv_en == VECS[i].drv, "R10", drv_en, VECS[i].drv);
            check(cfg_out == VECS[i].cfg, "R11", cfg_out, VECS[i].cfg);
        end

        send(2'd0, 4'h0);
        check(stat_vld && stat_word == 8'h03, "R7", stat_word, 8'h03);
        @(posedge clk); @(negedge clk);
        check(!stat_vld, "R7", stat_vld, 0);

        send(2'd2, 4'h0);
        check(stat_rs && op_mode == 2'b00 && drain_en && !pump_en, "R3", op_mode, 0);
        send(2'd1, 4'h1);
        send(2'd3, 4'h3);
        send(2'd0, 4'h0);
        check(stat_vld && stat_word == 8'hC0, "R7", stat_word, 8'hC0);
        count_to_run(4, n);
        check(n == BUSY + 1, "R3", n, BUSY + 1);
        check(op_mode == 2'b10, "R6", op_mode, 2);
        check(cfg_out == PINS, "R6", cfg_out, PINS);

        pwr_ready = 1'b1;
        send(2'd1, 4'h1);
        check(op_mode == 2'b11 && drv_en, "R10", drv_en, 1);
        rst_pin_n = 1'b0;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        check(!stat_rs && op_mode == 2'b11, "R4", stat_rs, 0);
        @(posedge clk); @(negedge clk);
        check(stat_rs && drain_en && !drv_en, "R4", stat_rs, 1);
        repeat (10) begin
            @(posedge clk); @(negedge clk);
            if (!stat_rs) check(0, "R4", stat_rs, 1);
        end
        rst_pin_n = 1'b1;
        count_to_run(0, n);
        check(n == BUSY + 2, "R4", n, BUSY + 2);

        send(2'd1, 4'h1);
        check(drv_en, "R10", drv_en, 1);
        pwr_ready = 1'b0;
        @(posedge clk); @(negedge clk);
        check(!drv_en && pump_en, "R10", drv_en, 0);

        finish_run();
    end
endmodule